// File: doc/BRIEF.md
# Four-Quadrant Line-Noise Running Averager

This block removes periodic mains interference (50 Hz or 60 Hz) from the conversion results of eight channels. Upstream logic delivers one result per channel in each quarter of the line cycle. The block keeps the four most recent results of every channel, one for each 90-degree quadrant. For each incoming result it puts out the sum of that channel's four stored results. A line-synchronous disturbance has opposite signs half a cycle apart, so it sums to zero. Once a channel's window is full, its output is therefore refreshed every quarter cycle.

A new result for a channel overwrites that channel's oldest slot, which holds the result taken at the same phase one line cycle earlier. After four complete scans over all eight channels every window is full, and the filled flag rises on each result from then on. A bypass control passes a result straight through, sign-extended and unchanged, without touching the stored windows. A restart input empties all windows so that filling starts again. Quadrant timing and the sampling itself are handled upstream.

Top module: `quad_line_avg`

## Requirements
- R1: After reset, outValid, outSum and outFilled are 0, and every stored slot and write position is cleared, so the first result of a channel yields a sum equal to that result.
- R2: A result presented with inValid high and restart low produces outValid high one clock later, with outChan equal to its inChan. With inValid low, outValid is low one clock later.
- R3: outSum is a two's-complement value SAMP_W+2 bits wide (26 bits by default). In non-bypass mode it equals the new result plus the three other stored slots of that channel, and it never overflows, even with four full-scale results of either sign.
- R4: Each channel has four slots written in rotation. The fifth result of a channel replaces its first, the sixth replaces its second, and so on.
- R5: outFilled is 0 until a channel has received four non-bypass results since reset or restart, and 1 from the fourth onward. Slots not yet written count as zero in the sum.
- R6: With bypass high, outSum is the result sign-extended to SAMP_W+2 bits and outFilled is 1. The channel's stored slots and its write position are left unchanged, so the next non-bypass sum does not include the bypassed result.
- R7: A cycle with restart high clears all slots, write positions and fill counts. Any result presented in that cycle is discarded, and outValid is low one clock later.
- R8: Channels are independent. Results interleaved across channels in scan order (0 to 7) fill each window separately, and after four full scans every channel reports outFilled high with the sum of its own four results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous clear of all windows |
| inValid | input | 1 | A conversion result is presented this cycle |
| inChan | input | 3 | Channel index of the result |
| inData | input | SAMP_W | Signed conversion result |
| bypass | input | 1 | Pass the result through instead of averaging |
| outValid | output | 1 | Output strobe, one cycle after an accepted result |
| outChan | output | 3 | Channel of the output |
| outSum | output | SAMP_W+2 | Signed four-quadrant sum, or the passed-through result |
| outFilled | output | 1 | The channel's window holds four results |

## Verification
The assertions take for granted that inChan is always a legal index and that restart and inValid are never unknown while out of reset. The bench drives only channels 0 to 7 and changes inputs on the falling edge. The checks on latency and bypass compare against inputs from the previous edge. This assumes that a result is held for exactly one cycle, so the bench drops inValid after each accepted edge unless it drives a new result straight away.

// File: rtl/lna_pkg.sv
package lna_pkg;
  localparam int LNA_CH    = 8;
  localparam int LNA_SLOTS = 4;
  localparam int CH_W      = $clog2(LNA_CH);
  localparam int SLOT_W    = $clog2(LNA_SLOTS);
  localparam int FILL_W    = $clog2(LNA_SLOTS + 1);

  typedef struct packed {
    logic              accept;
    logic              passThru;
    logic              clrAll;
    logic [CH_W-1:0]   chan;
    logic [SLOT_W-1:0] slot;
    logic              nowFilled;
  } lnaStrobe_t;
endpackage

// File: rtl/lna_ctrl.sv
module lna_ctrl
  import lna_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart,
  input  logic                 inValid,
  input  logic [CH_W-1:0]      inChan,
  input  logic                 bypass,
  output lnaStrobe_t           st
);
  logic [LNA_CH-1:0][SLOT_W-1:0] wrPtr;
  logic [LNA_CH-1:0][FILL_W-1:0] fillCnt;

  always_comb begin
    st.clrAll    = restart;
    st.accept    = inValid && !restart && !bypass;
    st.passThru  = inValid && !restart && bypass;
    st.chan      = inChan;
    st.slot      = wrPtr[inChan];
    st.nowFilled = (fillCnt[inChan] >= FILL_W'(LNA_SLOTS - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr   <= '0;
      fillCnt <= '0;
    end else if (restart) begin
      wrPtr   <= '0;
      fillCnt <= '0;
    end else if (st.accept) begin
      wrPtr[inChan] <= wrPtr[inChan] + SLOT_W'(1);
      if (fillCnt[inChan] < FILL_W'(LNA_SLOTS))
        fillCnt[inChan] <= fillCnt[inChan] + FILL_W'(1);
    end
  end

  // R6: bypassed or idle cycles leave write positions and fill counts alone
  p_hold_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!st.accept && !restart) |=> ($stable(wrPtr) && $stable(fillCnt)));

  // R7: restart empties every channel's fill count
  p_restart_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (fillCnt == '0 && wrPtr == '0));

  generate
    for (genvar c = 0; c < LNA_CH; c++) begin : g_bound
      // R5: fill count saturates at the slot count
      p_fill_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fillCnt[c] <= FILL_W'(LNA_SLOTS));
    end
  endgenerate
endmodule

// File: rtl/lna_datapath.sv
module lna_datapath
  import lna_pkg::*;
#(
  parameter int SAMP_W = 24,
  localparam int SUM_W = SAMP_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  lnaStrobe_t               st,
  input  logic signed [SAMP_W-1:0] inData,
  output logic                     outValid,
  output logic [CH_W-1:0]          outChan,
  output logic signed [SUM_W-1:0]  outSum,
  output logic                     outFilled
);
  logic signed [SAMP_W-1:0] slotMem [LNA_CH][LNA_SLOTS];
  logic signed [SUM_W-1:0]  windowSum;

  function automatic logic signed [SUM_W-1:0] widen(input logic signed [SAMP_W-1:0] v);
    return {{(SUM_W - SAMP_W){v[SAMP_W-1]}}, v};
  endfunction

  always_comb begin
    windowSum = '0;
    for (int s = 0; s < LNA_SLOTS; s++) begin
      if (SLOT_W'(s) == st.slot) windowSum = windowSum + widen(inData);
      else                       windowSum = windowSum + widen(slotMem[st.chan][s]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < LNA_CH; c++)
        for (int s = 0; s < LNA_SLOTS; s++)
          slotMem[c][s] <= '0;
    end else if (st.clrAll) begin
      for (int c = 0; c < LNA_CH; c++)
        for (int s = 0; s < LNA_SLOTS; s++)
          slotMem[c][s] <= '0;
    end else if (st.accept) begin
      slotMem[st.chan][st.slot] <= inData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid  <= 1'b0;
      outChan   <= '0;
      outSum    <= '0;
      outFilled <= 1'b0;
    end else begin
      outValid <= st.accept || st.passThru;
      if (st.accept || st.passThru) begin
        outChan   <= st.chan;
        outSum    <= st.passThru ? widen(inData) : windowSum;
        outFilled <= st.passThru ? 1'b1 : st.nowFilled;
      end
    end
  end

  // R3: a full-scale window of either sign stays inside the sum range
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (outSum <= $signed(SUM_W'(LNA_SLOTS) * widen({1'b0, {(SAMP_W-1){1'b1}}}))
               && outSum >= $signed(SUM_W'(LNA_SLOTS) * widen({1'b1, {(SAMP_W-1){1'b0}}}))));
endmodule

// File: rtl/quad_line_avg.sv
module quad_line_avg
  import lna_pkg::*;
#(
  parameter int SAMP_W = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     restart,
  input  logic                     inValid,
  input  logic [CH_W-1:0]          inChan,
  input  logic signed [SAMP_W-1:0] inData,
  input  logic                     bypass,
  output logic                     outValid,
  output logic [CH_W-1:0]          outChan,
  output logic signed [SAMP_W+1:0] outSum,
  output logic                     outFilled
);
  lnaStrobe_t st;

  lna_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .restart(restart), .inValid(inValid),
    .inChan(inChan), .bypass(bypass), .st(st)
  );

  lna_datapath #(.SAMP_W(SAMP_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .inData(inData),
    .outValid(outValid), .outChan(outChan), .outSum(outSum), .outFilled(outFilled)
  );

  // R2: accepted result appears one clock later on its own channel
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !restart) |=> (outValid && outChan == $past(inChan)));

  // R2: no input, no output strobe
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  // R6: bypass passes the result through sign-extended, flagged filled
  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && bypass && !restart) |=>
      (outSum == {{2{$past(inData[SAMP_W-1])}}, $past(inData)} && outFilled));

  // R7: a result in a restart cycle is dropped
  p_restart_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !outValid);
endmodule

// File: tb/quad_line_avg_tb.sv
module quad_line_avg_tb;
  localparam int SAMP_W = 24;
  localparam int NV = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart = 1'b0;
  logic inValid = 1'b0;
  logic [2:0] inChan = '0;
  logic signed [SAMP_W-1:0] inData = '0;
  logic bypass = 1'b0;
  logic outValid;
  logic [2:0] outChan;
  logic signed [SAMP_W+1:0] outSum;
  logic outFilled;

  int nChk = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  quad_line_avg #(.SAMP_W(SAMP_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .inValid(inValid),
    .inChan(inChan), .inData(inData), .bypass(bypass),
    .outValid(outValid), .outChan(outChan), .outSum(outSum), .outFilled(outFilled)
  );

  // vector table: channel, data, bypass, expected sum, expected filled, requirement
  localparam int     vCh  [NV] = '{0, 1, 0, 0, 0, 0, 1, 1, 0};
  localparam int     vDat [NV] = '{10, -5, 20, 30, 40, 50, 7, 3, -100};
  localparam int     vByp [NV] = '{0, 0, 0, 0, 0, 0, 1, 0, 0};
  localparam int     vSum [NV] = '{10, -5, 30, 60, 100, 140, 7, -2, 20};
  localparam int     vFil [NV] = '{0, 0, 0, 0, 1, 1, 1, 0, 1};
  localparam string  vTag [NV] = '{"R1", "R1", "R3", "R3", "R5", "R4", "R6", "R6", "R4"};

  task automatic check(input string tag, input longint act, input longint exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input int ch, input longint d, input bit byp, input bit rs);
    @(negedge clk);
    inValid = 1'b1; inChan = 3'(ch); inData = SAMP_W'(d); bypass = byp; restart = rs;
    @(posedge clk);
    #1;
    inValid = 1'b0; bypass = 1'b0; restart = 1'b0;
  endtask

  task automatic expect_out(input string tag, input int ch, input longint s, input bit f);
    check({tag, " valid"}, longint'(outValid), 1);
    check({tag, " chan"}, longint'(outChan), ch);
    check({tag, " sum"}, longint'(outSum), s);
    check({tag, " filled"}, longint'(outFilled), f);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 reset valid", longint'(outValid), 0);
    check("R1 reset sum", longint'(outSum), 0);
    check("R1 reset filled", longint'(outFilled), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    // R2: idle gives no strobe
    check("R2 idle valid", longint'(outValid), 0);

    for (int i = 0; i < NV; i++) begin
      drive(vCh[i], vDat[i], vByp[i] != 0, 1'b0);
      expect_out(vTag[i], vCh[i], vSum[i], vFil[i] != 0);
    end

    // R2: strobe drops after the result
    @(posedge clk); #1;
    check("R2 strobe falls", longint'(outValid), 0);

    // R3: full-scale positive and negative windows
    for (int k = 0; k < 4; k++) drive(2, 64'sd8388607, 1'b0, 1'b0);
    expect_out("R3 max", 2, 64'sd33554428, 1'b1);
    for (int k = 0; k < 4; k++) drive(3, -64'sd8388608, 1'b0, 1'b0);
    expect_out("R3 min", 3, -64'sd33554432, 1'b1);

    // R6: bypass of a negative value is sign-extended
    drive(4, -64'sd9, 1'b1, 1'b0);
    expect_out("R6 neg bypass", 4, -9, 1'b1);

    // R7: restart drops the result and empties windows
    drive(0, 999, 1'b0, 1'b1);
    check("R7 dropped", longint'(outValid), 0);
    drive(0, 5, 1'b0, 1'b0);
    expect_out("R7 cleared", 0, 5, 1'b0);

    // R8: four and then five interleaved scans over all channels
    drive(0, 0, 1'b0, 1'b1);
    for (int scan = 1; scan <= 5; scan++) begin
      for (int ch = 0; ch < 8; ch++) begin
        longint es;
        es = 0;
        for (int s = (scan > 4 ? scan - 3 : 1); s <= scan; s++) es += s * 100 + ch;
        drive(ch, scan * 100 + ch, 1'b0, 1'b0);
        expect_out(scan >= 4 ? "R8 full" : "R8 fill", ch, es, scan >= 4);
      end
    end

    @(posedge clk); #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule